// File: doc/BRIEF.md
# Bridge Quiesce and Sub-Block Reset Sequencer

This block brings a sub-block up and down when that sub-block reaches the rest of the chip through two asynchronous bus bridges: one facing its bus managers and one facing its subordinates. Each bridge is driven by a stop-request output and answers with an acknowledge status. The acknowledge stays high while a stop-request change is still being settled. The sequencer drives the sub-block reset release line, the sub-block clock enable and both stop requests, in a fixed order, for three operations: power-on, power-off, and a reset cycle (power-off followed by power-on).

Power-on first runs the clock for a fixed number of cycles with reset held, so the reset can reach every flop. It then stops the clock, releases reset and restarts the clock. After that it opens the manager bridge and then the subordinate bridge. Power-off closes the bridges in the opposite order, then gates the clock and asserts reset. Each bridge handshake has a timeout counted in clock cycles. On a timeout the sequence rolls back as far as it safely can and ends with an error flag. A sub-block with no bridges skips every handshake.

Top module: `bridge_gate_seq`

## Requirements
- R1: After synchronous reset: reset release line low, clock enable low, both stop requests high, done and error low.
- R2: Power-on holds reset low and the clock enabled for exactly PULSE_CYC cycles. It then gates the clock for at least one cycle before releasing reset, and re-enables the clock after the release.
- R3: Power-on clears the manager stop request and waits for that handshake before it clears the subordinate stop request. On success it ends with a one-cycle done, error low, reset released, clock on and both stop requests low.
- R4: A handshake succeeds when the acknowledge, after two-flop synchronization, reads low once the settle window of SYNC_STAGES+1 cycles has passed. A handshake still pending after HS_TO_CYC cycles fails. A failing manager enable keeps its stop request low for exactly HS_TO_CYC cycles.
- R5: If the subordinate enable times out, both stop requests are set and the manager disable handshake runs (its result is ignored). The clock is then gated and reset asserted, with done and error.
- R6: If the manager enable times out, the manager stop request is set again, the clock is gated and reset asserted, with done and error.
- R7: Power-off sets the subordinate stop request first and the manager stop request only after that handshake succeeds. It then gates the clock and asserts reset, ending with done and error low.
- R8: If the subordinate disable times out, power-off aborts with done and error. Clock, reset and the manager stop request keep their values.
- R9: If the manager disable times out, the subordinate stop request is cleared again (that handshake's result is ignored), and the operation ends with done and error. Clock and reset keep their values.
- R10: A reset-cycle request performs a full power-off and then a power-on. If the power-off fails, no power-on follows and the operation ends with error.
- R11: With bridge_en low, every handshake completes at once, the stop requests never change and the acknowledge inputs have no effect.
- R12: Requests are taken only while idle, including the cycle in which done is high. When several arrive together, reset-cycle wins over power-off, which wins over power-on. Requests that arrive while busy are dropped.
- R13: Whenever reset is asserted, both stop requests are high. Error is only ever high together with done, and done lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bridge_en | input | 1 | High when the sub-block has bridges; low skips handshakes |
| req_on | input | 1 | Power-on request |
| req_off | input | 1 | Power-off request |
| req_cycle | input | 1 | Reset-cycle request (off then on) |
| mgr_ack_i | input | 1 | Manager bridge acknowledge, asynchronous, high while pending |
| sub_ack_i | input | 1 | Subordinate bridge acknowledge, asynchronous, high while pending |
| blk_rst_n_o | output | 1 | Sub-block reset release (1 = released) |
| clk_en_o | output | 1 | Sub-block clock enable |
| mgr_stop_o | output | 1 | Manager bridge stop request |
| sub_stop_o | output | 1 | Subordinate bridge stop request |
| done_o | output | 1 | One-cycle end-of-operation strobe |
| err_o | output | 1 | Operation ended on a handshake timeout (valid with done) |

## Verification
Two events can fall in the same cycle. One is the done strobe of one operation together with a fresh request. The other is two or three requests raised together. For the first, the bench raises the next request in the very cycle it sees done, with no idle gap, and requires a second done within a few cycles. For the second, the bench raises off with on, and off with reset-cycle, from the powered-down state. The winner is then judged from the final outputs and from whether the clock enable ever rose during the operation. A request injected part-way through a power-off must leave the block powered down with no further done.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE,
        ST_GATE,
        ST_RELEASE,
        ST_MGR_EN,
        ST_SUB_EN,
        ST_RB_SUB,
        ST_RB_END,
        ST_SUB_DIS,
        ST_MGR_DIS,
        ST_RB_MGR,
        ST_OFF_END
    } seq_state_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_ON,
        REQ_OFF,
        REQ_CYCLE
    } req_kind_e;

    typedef enum logic {
        SIDE_MGR,
        SIDE_SUB
    } side_e;

    typedef struct packed {
        logic rst_n;
        logic clk_en;
        logic mgr_stop;
        logic sub_stop;
    } drive_t;

    localparam drive_t DRIVE_OFF = '{rst_n: 1'b0, clk_en: 1'b0, mgr_stop: 1'b1, sub_stop: 1'b1};

    // Reset-cycle outranks power-off, which outranks power-on.
    function automatic req_kind_e pick_req(input logic on, input logic off, input logic cyc);
        if (cyc)      return REQ_CYCLE;
        else if (off) return REQ_OFF;
        else if (on)  return REQ_ON;
        else          return REQ_NONE;
    endfunction

    function automatic logic is_wait(input seq_state_e s);
        return (s == ST_MGR_EN) || (s == ST_SUB_EN) || (s == ST_RB_SUB) ||
               (s == ST_SUB_DIS) || (s == ST_MGR_DIS) || (s == ST_RB_MGR);
    endfunction

    function automatic side_e wait_side(input seq_state_e s);
        if ((s == ST_MGR_EN) || (s == ST_RB_SUB) || (s == ST_MGR_DIS))
            return SIDE_MGR;
        return SIDE_SUB;
    endfunction

endpackage

// File: rtl/bgs_sync.sv
module bgs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '0;
                else     pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '0;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/bgs_hs_timer.sv
module bgs_hs_timer #(
    parameter int TIMEOUT = 125,
    parameter int SETTLE  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic bypass,
    input  logic ack,
    output logic ok,
    output logic fail
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] SETTLE_V = CW'(SETTLE);
    localparam logic [CW-1:0] LAST_V   = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    // Acknowledge is ignored until the synchronizer has seen the stop change.
    assign ok   = active && (bypass || ((cnt >= SETTLE_V) && !ack));
    assign fail = active && !ok && (cnt == LAST_V);

    always_ff @(posedge clk) begin
        if (rst)                         cnt <= '0;
        else if (active && !ok && !fail) cnt <= cnt + CW'(1);
        else                             cnt <= '0;
    end
endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
    import bgs_pkg::*;
#(
    parameter int PULSE_CYC   = 128,
    parameter int HS_TO_CYC   = 125,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bridge_en,
    input  logic req_on,
    input  logic req_off,
    input  logic req_cycle,
    input  logic mgr_ack_i,
    input  logic sub_ack_i,
    output logic blk_rst_n_o,
    output logic clk_en_o,
    output logic mgr_stop_o,
    output logic sub_stop_o,
    output logic done_o,
    output logic err_o
);
    localparam int PCNT_W     = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam int SETTLE_CYC = SYNC_STAGES + 1;
    localparam logic [PCNT_W-1:0] PLAST = PCNT_W'(PULSE_CYC - 1);

    seq_state_e        state;
    drive_t            drv;
    logic              done_q, err_q, chain_q;
    logic [PCNT_W-1:0] pcnt;
    logic [1:0]        ack_s;
    logic              ack_sel, hs_ok, hs_fail;
    req_kind_e         req_k;

    bgs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sub_ack_i, mgr_ack_i}),
        .q   (ack_s)
    );

    assign ack_sel = (wait_side(state) == SIDE_MGR) ? ack_s[0] : ack_s[1];

    bgs_hs_timer #(.TIMEOUT(HS_TO_CYC), .SETTLE(SETTLE_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (is_wait(state)),
        .bypass (!bridge_en),
        .ack    (ack_sel),
        .ok     (hs_ok),
        .fail   (hs_fail)
    );

    assign req_k = pick_req(req_on, req_off, req_cycle);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            drv     <= DRIVE_OFF;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            chain_q <= 1'b0;
            pcnt    <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_k == REQ_ON) begin
                        state      <= ST_PULSE;
                        drv.rst_n  <= 1'b0;
                        drv.clk_en <= 1'b1;
                        pcnt       <= '0;
                        if (bridge_en) begin
                            drv.mgr_stop <= 1'b1;
                            drv.sub_stop <= 1'b1;
                        end
                    end else if (req_k != REQ_NONE) begin
                        state   <= ST_SUB_DIS;
                        chain_q <= (req_k == REQ_CYCLE);
                        if (bridge_en) drv.sub_stop <= 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (pcnt == PLAST) begin
                        drv.clk_en <= 1'b0;
                        state      <= ST_GATE;
                    end else begin
                        pcnt <= pcnt + PCNT_W'(1);
                    end
                end
                ST_GATE: begin
                    drv.rst_n <= 1'b1;
                    state     <= ST_RELEASE;
                end
                ST_RELEASE: begin
                    drv.clk_en <= 1'b1;
                    if (bridge_en) drv.mgr_stop <= 1'b0;
                    state <= ST_MGR_EN;
                end
                ST_MGR_EN: begin
                    if (hs_ok) begin
                        if (bridge_en) drv.sub_stop <= 1'b0;
                        state <= ST_SUB_EN;
                    end else if (hs_fail) begin
                        drv.mgr_stop <= 1'b1;
                        state        <= ST_RB_END;
                    end
                end
                ST_SUB_EN: begin
                    if (hs_ok) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (hs_fail) begin
                        drv.sub_stop <= 1'b1;
                        drv.mgr_stop <= 1'b1;
                        state        <= ST_RB_SUB;
                    end
                end
                ST_RB_SUB: begin
                    if (hs_ok || hs_fail) state <= ST_RB_END;
                end
                ST_RB_END: begin
                    drv.clk_en <= 1'b0;
                    drv.rst_n  <= 1'b0;
                    done_q     <= 1'b1;
                    err_q      <= 1'b1;
                    state      <= ST_IDLE;
                end
                ST_SUB_DIS: begin
                    if (hs_ok) begin
                        if (bridge_en) drv.mgr_stop <= 1'b1;
                        state <= ST_MGR_DIS;
                    end else if (hs_fail) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_MGR_DIS: begin
                    if (hs_ok) begin
                        drv.clk_en <= 1'b0;
                        drv.rst_n  <= 1'b0;
                        state      <= ST_OFF_END;
                    end else if (hs_fail) begin
                        drv.sub_stop <= 1'b0;
                        state        <= ST_RB_MGR;
                    end
                end
                ST_RB_MGR: begin
                    if (hs_ok || hs_fail) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_OFF_END: begin
                    if (chain_q) begin
                        chain_q    <= 1'b0;
                        drv.clk_en <= 1'b1;
                        pcnt       <= '0;
                        state      <= ST_PULSE;
                    end else begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign blk_rst_n_o = drv.rst_n;
    assign clk_en_o    = drv.clk_en;
    assign mgr_stop_o  = drv.mgr_stop;
    assign sub_stop_o  = drv.sub_stop;
    assign done_o      = done_q;
    assign err_o       = err_q;

    // Reset is released only while the clock is gated.
    assert_release_gated_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(blk_rst_n_o) |-> !clk_en_o);

    // The manager side opens while the subordinate side is still stopped.
    assert_mgr_first_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(mgr_stop_o) |-> sub_stop_o);

    // The manager side closes only once the subordinate side is stopped.
    assert_sub_first_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mgr_stop_o) |-> sub_stop_o);

    assert_stopped_in_reset_R13: assert property (@(posedge clk) disable iff (rst)
        !blk_rst_n_o |-> (mgr_stop_o && sub_stop_o));

    assert_err_with_done_R13: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    assert_done_single_R13: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: tb/bridge_gate_seq_bench.sv
module bridge_gate_seq_bench;
    localparam int PULSE_CYC = 128;
    localparam int HS_TO     = 125;

    typedef struct packed {
        logic [1:0] op;     // 1 on, 2 off, 3 reset-cycle
        logic       brg;
        logic       fack;
        logic [9:0] mh;
        logic [9:0] sh;
        logic       xerr;
        logic [3:0] xout;   // {rst_n, clk_en, mgr_stop, sub_stop}
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 1'b1, 1'b0, 10'd2,   10'd2,   1'b0, 4'b1100, 4'd3 },  // R3 on
        '{2'd2, 1'b1, 1'b0, 10'd2,   10'd2,   1'b0, 4'b0011, 4'd7 },  // R7 off
        '{2'd1, 1'b1, 1'b0, 10'd2,   10'd500, 1'b1, 4'b0011, 4'd5 },  // R5 sub enable timeout
        '{2'd1, 1'b1, 1'b0, 10'd500, 10'd2,   1'b1, 4'b0011, 4'd6 },  // R6 mgr enable timeout
        '{2'd1, 1'b1, 1'b0, 10'd2,   10'd2,   1'b0, 4'b1100, 4'd3 },  // R3 on again
        '{2'd2, 1'b1, 1'b0, 10'd500, 10'd2,   1'b1, 4'b1110, 4'd9 },  // R9 mgr disable timeout
        '{2'd3, 1'b1, 1'b0, 10'd2,   10'd2,   1'b0, 4'b1100, 4'd10},  // R10 reset-cycle
        '{2'd2, 1'b1, 1'b0, 10'd2,   10'd500, 1'b1, 4'b1101, 4'd8 },  // R8 sub disable timeout
        '{2'd3, 1'b1, 1'b0, 10'd2,   10'd2,   1'b0, 4'b1100, 4'd10},  // R10 recover
        '{2'd3, 1'b1, 1'b0, 10'd2,   10'd500, 1'b1, 4'b1101, 4'd10},  // R10 off fails, no on
        '{2'd2, 1'b1, 1'b0, 10'd2,   10'd2,   1'b0, 4'b0011, 4'd7 },  // R7 off
        '{2'd1, 1'b0, 1'b1, 10'd0,   10'd0,   1'b0, 4'b1111, 4'd11},  // R11 on, no bridge
        '{2'd3, 1'b0, 1'b1, 10'd0,   10'd0,   1'b0, 4'b1111, 4'd11},  // R11 cycle, no bridge
        '{2'd2, 1'b0, 1'b1, 10'd0,   10'd0,   1'b0, 4'b0011, 4'd11}   // R11 off, no bridge
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bridge_en = 1'b1, req_on = 1'b0, req_off = 1'b0, req_cycle = 1'b0;
    logic mgr_ack, sub_ack;
    logic blk_rst_n_o, clk_en_o, mgr_stop_o, sub_stop_o, done_o, err_o;

    always #4 clk = ~clk;

    bridge_gate_seq u_bridge_gate_seq (
        .clk         (clk),
        .rst         (rst),
        .bridge_en   (bridge_en),
        .req_on      (req_on),
        .req_off     (req_off),
        .req_cycle   (req_cycle),
        .mgr_ack_i   (mgr_ack),
        .sub_ack_i   (sub_ack),
        .blk_rst_n_o (blk_rst_n_o),
        .clk_en_o    (clk_en_o),
        .mgr_stop_o  (mgr_stop_o),
        .sub_stop_o  (sub_stop_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    // Bridge model: each stop-request change raises acknowledge for a hold time.
    int   mhold = 2, shold = 2, mcnt, scnt;
    logic mprev, sprev, fack = 1'b0;
    always @(posedge clk) begin
        if (rst) begin
            mprev <= 1'b1; sprev <= 1'b1; mcnt <= 0; scnt <= 0;
        end else begin
            mprev <= mgr_stop_o;
            sprev <= sub_stop_o;
            if (mgr_stop_o != mprev) mcnt <= mhold;
            else if (mcnt != 0)      mcnt <= mcnt - 1;
            if (sub_stop_o != sprev) scnt <= shold;
            else if (scnt != 0)      scnt <= scnt - 1;
        end
    end
    assign mgr_ack = fack | (mcnt != 0);
    assign sub_ack = fack | (scnt != 0);

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    int n_bad13 = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!blk_rst_n_o && !(mgr_stop_o && sub_stop_o)) n_bad13++;
            if (err_o && !done_o) n_bad13++;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    int n_cr, n_ck, n_m0, rel_bad, fm0, fs0, fm1, fs1;

    task automatic fire(input bit a, input bit b, input bit c);
        req_on = a; req_off = b; req_cycle = c;
    endtask

    task automatic op_wait(output bit e, output int ncyc);
        bit got = 1'b0;
        logic prev_r = blk_rst_n_o;
        n_cr = 0; n_ck = 0; n_m0 = 0; rel_bad = 0;
        fm0 = -1; fs0 = -1; fm1 = -1; fs1 = -1;
        e = 1'b0; ncyc = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (k == 0) fire(1'b0, 1'b0, 1'b0);
            if (clk_en_o && !blk_rst_n_o) n_cr++;
            if (clk_en_o) n_ck++;
            if (!mgr_stop_o) n_m0++;
            if (blk_rst_n_o && !prev_r && clk_en_o) rel_bad++;
            prev_r = blk_rst_n_o;
            if (!mgr_stop_o && fm0 < 0) fm0 = k;
            if (!sub_stop_o && fs0 < 0) fs0 = k;
            if (mgr_stop_o && fm1 < 0) fm1 = k;
            if (sub_stop_o && fs1 < 0) fs1 = k;
            if (done_o) begin
                e = err_o; ncyc = k + 1; got = 1'b1;
                break;
            end
        end
        chk(got, "R12 operation reached done", int'(got), 1);
    endtask

    task automatic quiet();
        fack = 1'b0;
        for (int k = 0; k < 1000; k++) begin
            if (!mgr_ack && !sub_ack) break;
            @(negedge clk);
        end
    endtask

    function automatic int outs();
        return int'({blk_rst_n_o, clk_en_o, mgr_stop_o, sub_stop_o});
    endfunction

    initial begin
        #(64'd8 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R12: actual hung, expected completion (%0d, %0d)", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit e;
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(outs() == 4'b0011, "R1 outputs after reset", outs(), 4'b0011);
        chk(!done_o && !err_o, "R1 done/err after reset", int'({done_o, err_o}), 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            quiet();
            mhold = int'(VEC[i].mh); shold = int'(VEC[i].sh);
            bridge_en = VEC[i].brg; fack = VEC[i].fack;
            fire(VEC[i].op == 2'd1, VEC[i].op == 2'd2, VEC[i].op == 2'd3);
            op_wait(e, n);
            chk(e == VEC[i].xerr, $sformatf("R%0d vector %0d error flag", VEC[i].rq, i),
                int'(e), int'(VEC[i].xerr));
            chk(outs() == int'(VEC[i].xout), $sformatf("R%0d vector %0d outputs", VEC[i].rq, i),
                outs(), int'(VEC[i].xout));
        end
        fack = 1'b0; bridge_en = 1'b1;

        // R2 / R3: pulse length, gated release, manager before subordinate
        quiet(); mhold = 2; shold = 2;
        fire(1'b1, 1'b0, 1'b0); op_wait(e, n);
        chk(n_cr == PULSE_CYC, "R2 clock cycles with reset held", n_cr, PULSE_CYC);
        chk(rel_bad == 0, "R2 release while clock gated", rel_bad, 0);
        chk(fm0 >= 0 && fm0 < fs0, "R3 manager opens first", fm0, fs0 - 1);

        // R7: subordinate closes first, then gate and reset
        quiet();
        fire(1'b0, 1'b1, 1'b0); op_wait(e, n);
        chk(fs1 >= 0 && fs1 < fm1, "R7 subordinate closes first", fs1, fm1 - 1);
        chk(outs() == 4'b0011 && !e, "R7 powered down", outs(), 4'b0011);

        // R4: manager stop held low for exactly the timeout window
        quiet(); mhold = 500;
        fire(1'b1, 1'b0, 1'b0); op_wait(e, n);
        chk(n_m0 == HS_TO, "R4 timeout window length", n_m0, HS_TO);
        chk(e == 1'b1, "R4 timeout reported", int'(e), 1);

        // R12: off beats on when raised together
        quiet(); mhold = 2;
        fire(1'b1, 1'b1, 1'b0); op_wait(e, n);
        chk(n_ck == 0, "R12 off wins over on (clock never enabled)", n_ck, 0);
        chk(outs() == 4'b0011, "R12 off wins over on outputs", outs(), 4'b0011);

        // R12: reset-cycle beats off
        quiet();
        fire(1'b0, 1'b1, 1'b1); op_wait(e, n);
        chk(outs() == 4'b1100 && !e, "R12 reset-cycle wins over off", outs(), 4'b1100);

        // R12: request while busy is dropped
        quiet();
        fire(1'b0, 1'b1, 1'b0);
        @(negedge clk); fire(1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        fire(1'b1, 1'b0, 1'b0);
        op_wait(e, n);
        chk(outs() == 4'b0011, "R12 busy request dropped outputs", outs(), 4'b0011);
        n = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (done_o || clk_en_o) n++;
        end
        chk(n == 0, "R12 no activity after dropped request", n, 0);

        // R12: request in the done cycle is accepted
        quiet(); bridge_en = 1'b0;
        fire(1'b1, 1'b0, 1'b0); op_wait(e, n);
        chk(outs() == 4'b1111, "R11 no-bridge on outputs", outs(), 4'b1111);
        fire(1'b0, 1'b1, 1'b0); op_wait(e, n);
        chk(n <= 8, "R12 request taken in done cycle", n, 8);
        chk(outs() == 4'b0011, "R12 back-to-back off outputs", outs(), 4'b0011);

        // R13 safety invariant observed over the whole run
        chk(n_bad13 == 0, "R13 reset implies stopped, error only with done", n_bad13, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule